// File: doc/BRIEF.md
# Heartbeat Watchdog with Supply-Low Override

This block watches a single heartbeat line driven by a processor and lowers an active-low alarm output when that line has stayed at one level for longer than a programmed number of clock ticks. Any change of the heartbeat level, upward or downward, restarts the count. The count is held at zero while the system reset is active and while the heartbeat pin is reported as floating, so the alarm can only fire once the processor is running and driving the line.

A separate supply-low flag overrides the timer and pulls the alarm low whenever it is set, whether or not the count has run out. The alarm returns high as soon as the flag clears, provided the timer has not expired. The block never issues a reset itself. Wiring the alarm back to a manual reset input outside the block gives a reset on timeout.

The heartbeat passes through a two-flop synchronizer before edge detection. The timeout is a parameter in clock ticks: the default of 160,000,000 ticks gives 1.6 s at 100 MHz, and a short value is used in simulation.

Top module: `hbeat_watchdog`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, `wdog_n` is 1.
- R2: When no clear occurs for `TIMEOUT_CYC` clock edges in a row, `wdog_n` goes to 0 on the next edge. A heartbeat change applied before clock edge k counts as a clear at edge k+2, because of the two synchronizer stages.
- R3: A rising heartbeat transition and a falling heartbeat transition each restart the timeout count.
- R4: Once `wdog_n` is 0 because of expiry, it stays 0 until a clear occurs: a heartbeat transition, `sys_rst_n` at 0, or `hb_float` at 1.
- R5: While `sys_rst_n` is 0, the count is held at zero. Timing starts only once `sys_rst_n` returns to 1.
- R6: `supply_low` at 1 makes `wdog_n` 0 on the next clock edge regardless of the timer. When `supply_low` returns to 0, `wdog_n` returns to 1 on the next edge if the timer has not expired.
- R7: While `hb_float` is 1, the timer is held clear and `wdog_n` follows only `supply_low`.
- R8: A heartbeat transition detected on the same edge on which the count would expire clears the count, and `wdog_n` stays 1.
- R9: A heartbeat pulse that holds its new level for one clock period is recognized as a pair of transitions and restarts the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| heartbeat | input | 1 | Processor heartbeat level, asynchronous to `clk` |
| hb_float | input | 1 | 1 when the heartbeat pin is sensed as floating |
| sys_rst_n | input | 1 | System reset, active low; holds the timer clear |
| supply_low | input | 1 | 1 while the supply is below its reset threshold |
| wdog_n | output | 1 | Registered watchdog alarm, active low |

## Verification
The bench builds the block with `TIMEOUT_CYC` set to 20 and the default two synchronizer stages. With that setting, expiry, holding low, and recovery each take a few dozen cycles, so they can be tested many times over. A sweep can also place a heartbeat change at every cycle around the expiry edge, which reaches the case where an edge and expiry land on the same cycle. Single-cycle heartbeat pulses and supply-low pulses during a float interval are both short enough to check against the reference model on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Counter width for a terminal count of n ticks (at least one bit).
  function automatic int ctr_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/hb_edge_sync.sv
module hb_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hb_async,
  output logic hb_edge
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= hb_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[STAGES-1];
  end

  // Either polarity of change counts as activity.
  assign hb_edge = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/wd_expiry_timer.sv
module wd_expiry_timer #(
  parameter int TIMEOUT_CYC = 160_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic expired
);
  localparam int CW = wdog_pkg::ctr_w(TIMEOUT_CYC);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          exp_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (!exp_q) begin
      if (cnt_q == LAST) exp_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = exp_q;
endmodule

// File: rtl/hbeat_watchdog.sv
module hbeat_watchdog #(
  parameter int TIMEOUT_CYC = 160_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic heartbeat,
  input  logic hb_float,
  input  logic sys_rst_n,
  input  logic supply_low,
  output logic wdog_n
);
  logic hb_edge;
  logic expired;
  logic tmr_clr;
  logic wdog_q;

  hb_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .hb_async (heartbeat),
    .hb_edge  (hb_edge)
  );

  // Edge, system reset and a floating pin all hold the count at zero;
  // a clear wins over expiry in the same cycle.
  assign tmr_clr = hb_edge | ~sys_rst_n | hb_float;

  wd_expiry_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clr     (tmr_clr),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) wdog_q <= 1'b1;
    else     wdog_q <= ~(expired | supply_low);
  end

  assign wdog_n = wdog_q;
endmodule

// File: rtl/hbeat_watchdog_chk.sv
module hbeat_watchdog_chk #(
  parameter int TIMEOUT_CYC = 20
) (
  input logic clk,
  input logic rst,
  input logic hb_float,
  input logic sys_rst_n,
  input logic supply_low,
  input logic hb_edge,
  input logic expired,
  input logic wdog_n
);
  // Independent count of quiet cycles, used instead of a long $past window.
  logic [31:0] quiet;
  always_ff @(posedge clk) begin
    if (rst || hb_edge || !sys_rst_n || hb_float) quiet <= '0;
    else if (quiet < 32'(TIMEOUT_CYC)) quiet <= quiet + 1;
  end

  p_reset_high_r1: assert property (@(posedge clk) rst |=> wdog_n);

  p_no_early_expiry_r2: assert property (@(posedge clk) disable iff (rst)
    expired |-> (quiet >= 32'(TIMEOUT_CYC)));

  p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
    (!expired && !supply_low) |=> wdog_n);

  p_edge_clears_r3: assert property (@(posedge clk) disable iff (rst)
    hb_edge |=> !expired);

  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (expired && !hb_edge && sys_rst_n && !hb_float) |=> expired);

  p_sysrst_clears_r5: assert property (@(posedge clk) disable iff (rst)
    !sys_rst_n |=> !expired);

  p_supply_forces_r6: assert property (@(posedge clk) disable iff (rst)
    supply_low |=> !wdog_n);

  p_float_clears_r7: assert property (@(posedge clk) disable iff (rst)
    hb_float |=> !expired);
endmodule

bind hbeat_watchdog hbeat_watchdog_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hb_float   (hb_float),
  .sys_rst_n  (sys_rst_n),
  .supply_low (supply_low),
  .hb_edge    (hb_edge),
  .expired    (expired),
  .wdog_n     (wdog_n)
);

// File: tb/test_hbeat_watchdog.sv
module test_hbeat_watchdog;
  localparam int T = 20;

  logic clk = 1'b0;
  logic rst, heartbeat, hb_float, sys_rst_n, supply_low;
  logic wdog_n;

  int checks = 0;
  int errors = 0;
  string req = "R1";

  // Reference model state: three heartbeat history samples and a quiet age.
  int h_s1 = 0, h_s2 = 0, h_prev = 0;
  int age = 0;
  int m_wd = 1;

  always #5 clk = ~clk;

  hbeat_watchdog #(.TIMEOUT_CYC(T), .SYNC_STAGES(2)) i_hbeat_watchdog (
    .clk(clk), .rst(rst), .heartbeat(heartbeat), .hb_float(hb_float),
    .sys_rst_n(sys_rst_n), .supply_low(supply_low), .wdog_n(wdog_n)
  );

  task automatic check(input string tag, input logic exp_v);
    checks++;
    if (wdog_n !== exp_v) begin
      errors++;
      $display("FAIL %s: wdog_n actual %b expected %b at %0t", tag, wdog_n, exp_v, $time);
    end
  endtask

  // Advance one clock: update the model for the edge just passed, compare.
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      begin
        bit moved;
        int old_age;
        moved   = (h_s2 != h_prev);
        old_age = age;
        if (rst) begin
          m_wd = 1; age = 0; h_s1 = 0; h_s2 = 0; h_prev = 0;
        end else begin
          m_wd   = ((old_age >= T) || supply_low) ? 0 : 1;
          h_prev = h_s2; h_s2 = h_s1; h_s1 = int'(heartbeat);
          if (moved || hb_float || !sys_rst_n) age = 0;
          else if (age < T) age = age + 1;
        end
      end
      check(req, logic'(m_wd[0]));
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        errors++; checks++;
        $display("FAIL watchdog: run actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst = 1; heartbeat = 0; hb_float = 0; sys_rst_n = 1; supply_low = 0;
    req = "R1"; step(3);
    check("R1", 1'b1);
    rst = 0; step(1);
    check("R1", 1'b1);

    // R5: system reset held low keeps the timer clear
    req = "R5"; sys_rst_n = 0; step(60);
    check("R5", 1'b1);
    sys_rst_n = 1; step(15);
    check("R5", 1'b1);

    // R2: expiry after quiet interval
    req = "R2"; step(10);
    check("R2", 1'b0);

    // R4: stays low with no clear
    req = "R4"; step(40);
    check("R4", 1'b0);

    // R3: rising transition clears
    req = "R3"; heartbeat = 1; step(5);
    check("R3", 1'b1);
    // periodic alternating toggles keep it high
    for (int k = 0; k < 12; k++) begin
      heartbeat = ~heartbeat; step(12);
    end
    check("R3", 1'b1);
    // falling transition clears after expiry
    heartbeat = 1; step(40);
    check("R3", 1'b0);
    heartbeat = 0; step(5);
    check("R3", 1'b1);

    // R9: single-cycle pulse after expiry
    req = "R9"; step(40);
    check("R9", 1'b0);
    heartbeat = 1; step(1); heartbeat = 0; step(5);
    check("R9", 1'b1);

    // R6: supply low override
    req = "R6"; supply_low = 1; step(2);
    check("R6", 1'b0);
    supply_low = 0; step(2);
    check("R6", 1'b1);

    // R7: floating pin disables the timer
    req = "R7"; hb_float = 1; step(80);
    check("R7", 1'b1);
    supply_low = 1; step(3);
    check("R7", 1'b0);
    supply_low = 0; step(3);
    check("R7", 1'b1);
    hb_float = 0; step(30);
    check("R7", 1'b0);

    // R8: transition placed around the expiry edge, model compared each clock
    req = "R8";
    for (int d = T - 4; d <= T + 3; d++) begin
      heartbeat = ~heartbeat; step(1);
      heartbeat = heartbeat; step(d);
      heartbeat = ~heartbeat; step(6);
      step(T + 4);
    end
    check("R8", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule